// File: doc/BRIEF.md
# Direct-Mapped Split-Tag Translation Buffer

This block turns virtual addresses into physical addresses for 4 KiB pages by looking them up in a small direct-mapped buffer. Each slot holds one physical frame number. Three separate tag banks sit over those frame slots, one for instruction fetch, one for data load and one for data store. A page can therefore translate for one kind of access and still miss for another, until the refill source installs it for that kind as well.

A requester presents a virtual address, an access kind and a valid strobe. In the same cycle the block answers either with a hit and the physical address, or with a miss request that carries the address and kind toward a refill agent. That agent later writes a frame back through the fill port for one kind. Writing the page-table base register keeps the value page-aligned and throws away every tag in all three banks. The table walker, permission checks and memory are outside this block.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot of all three tag banks is empty, so every lookup misses, and the page-table base reads as zero.
- R2: A lookup uses slot (virtual page number mod ENTRIES) and hits only if that slot is valid in the selected bank and its stored tag equals the full virtual page number (address bits above bit 11). An address that shares the slot but differs in any upper bit misses.
- R3: On a hit the physical address is the stored frame number in bits PA_W-1..12, and the virtual address bits 11..0 unchanged in bits 11..0.
- R4: The kind code selects the bank: 2'b00 fetch, 2'b10 store, 2'b01 and 2'b11 load.
- R5: A fill writes the shared frame slot and sets tag and valid only in the bank of its own kind; the other two banks keep their contents.
- R6: With the strobe high and no hit, the miss request is high and carries the requested address and kind; with the strobe low, both hit and miss request are low.
- R7: A write of the page-table base stores the value with bits 11..0 forced to zero and, from the next cycle on, all three banks are empty.
- R8: When a base write and a fill fall in the same cycle, the flush wins and the filled entry is not valid afterwards.
- R9: Lookup is combinational; a fill is seen by lookups only from the cycle after the clock edge that takes it.
- R10: All kinds share one frame slot per index, so a fill of one kind changes the physical address returned by another kind's still-valid tag at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup strobe |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| req_kind_i | input | 2 | Access kind code (R4) |
| rsp_hit_o | output | 1 | Translation found |
| rsp_paddr_o | output | PA_W | Physical address, meaningful on hit |
| miss_req_o | output | 1 | Refill wanted |
| miss_vaddr_o | output | VA_W | Address of the missing access |
| miss_kind_o | output | 2 | Kind of the missing access |
| fill_valid_i | input | 1 | Install an entry |
| fill_vaddr_i | input | VA_W | Virtual address of the installed page |
| fill_kind_i | input | 2 | Bank to install into |
| fill_frame_i | input | PA_W-12 | Physical frame number |
| ptbase_we_i | input | 1 | Page-table base write, flushes all banks |
| ptbase_wdata_i | input | PA_W | New base value |
| ptbase_q_o | output | PA_W | Current page-aligned base |

## Verification
The bench builds the block with 32-bit virtual and physical addresses and 16 slots instead of 256. Sixteen slots put aliasing pairs such as pages 0x00003 and 0x00013 on the same index with small addresses, so the exact-tag rule and the shared frame slot can be shown directly. A 20-bit tag also lets a difference in the top address bit alone prove that the whole page number is compared.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int NUM_BANKS  = 3;
    localparam int BANK_FETCH = 0;
    localparam int BANK_LOAD  = 1;
    localparam int BANK_STORE = 2;

    typedef enum logic [1:0] {
        ACC_FETCH    = 2'b00,
        ACC_LOAD     = 2'b01,
        ACC_STORE    = 2'b10,
        ACC_LOAD_ALT = 2'b11
    } acc_kind_e;

    // Map an access kind code to its tag bank; unknown codes fall to load.
    function automatic logic [1:0] bank_of(input logic [1:0] kind);
        logic [1:0] b;
        case (kind)
            ACC_FETCH: b = 2'(BANK_FETCH);
            ACC_STORE: b = 2'(BANK_STORE);
            default:   b = 2'(BANK_LOAD);
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tlb_tag_bank.sv
module tlb_tag_bank #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 52,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    output logic             hit_o
);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.valid = '0;
        end else if (wr_en_i) begin
            st_d.valid[wr_idx_i] = 1'b1;
            st_d.tag[wr_idx_i]   = wr_tag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = st_q.valid[rd_idx_i] && (st_q.tag[rd_idx_i] == rd_tag_i);

    // Flush empties the bank, also over a same-cycle write.
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.valid == '0));

    // A write without flush leaves its slot valid with the written tag.
    assert_fill_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !flush_i) |=> (st_q.valid[$past(wr_idx_i)] &&
                                   st_q.tag[$past(wr_idx_i)] == $past(wr_tag_i)));

    // Without flush or write the valid set never changes.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !flush_i) |=> $stable(st_q.valid));

endmodule

// File: rtl/tlb_frame_bank.sv
module tlb_frame_bank #(
    parameter int ENTRIES = 256,
    parameter int FRAME_W = 52,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [FRAME_W-1:0] wr_frame_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [FRAME_W-1:0] rd_frame_o
);

    typedef struct packed {
        logic [ENTRIES-1:0][FRAME_W-1:0] frame;
    } frame_st_t;

    frame_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.frame[wr_idx_i] = wr_frame_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_frame_o = st_q.frame[rd_idx_i];

    // Written frame is visible in its slot on the following cycle.
    assert_frame_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.frame[$past(wr_idx_i)] == $past(wr_frame_i)));

endmodule

// File: rtl/tlb_base_reg.sv
module tlb_base_reg #(
    parameter int PA_W      = 64,
    parameter int PAGE_BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [PA_W-1:0] wdata_i,
    output logic [PA_W-1:0] base_o,
    output logic            flush_o
);

    typedef struct packed {
        logic [PA_W-1:0] base;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.base = {wdata_i[PA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o  = st_q.base;
    assign flush_o = we_i;

    assert_base_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (base_o[PA_W-1:PAGE_BITS] == $past(wdata_i[PA_W-1:PAGE_BITS]) &&
                  base_o[PAGE_BITS-1:0] == '0));

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 64,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 256,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int FRAME_W  = PA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic [VA_W-1:0]    req_vaddr_i,
    input  logic [1:0]         req_kind_i,
    output logic               rsp_hit_o,
    output logic [PA_W-1:0]    rsp_paddr_o,
    output logic               miss_req_o,
    output logic [VA_W-1:0]    miss_vaddr_o,
    output logic [1:0]         miss_kind_o,
    input  logic               fill_valid_i,
    input  logic [VA_W-1:0]    fill_vaddr_i,
    input  logic [1:0]         fill_kind_i,
    input  logic [FRAME_W-1:0] fill_frame_i,
    input  logic               ptbase_we_i,
    input  logic [PA_W-1:0]    ptbase_wdata_i,
    output logic [PA_W-1:0]    ptbase_q_o
);

    typedef struct packed {
        logic [IDX_W-1:0] rd_idx;
        logic [VPN_W-1:0] rd_tag;
        logic [1:0]       rd_bank;
        logic [IDX_W-1:0] wr_idx;
        logic [VPN_W-1:0] wr_tag;
        logic [1:0]       wr_bank;
        logic             wr_ok;
    } route_t;

    route_t             rt;
    logic               flush;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [FRAME_W-1:0] rd_frame;

    always_comb begin
        rt.rd_idx  = req_vaddr_i[PAGE_BITS +: IDX_W];
        rt.rd_tag  = req_vaddr_i[VA_W-1:PAGE_BITS];
        rt.rd_bank = bank_of(req_kind_i);
        rt.wr_idx  = fill_vaddr_i[PAGE_BITS +: IDX_W];
        rt.wr_tag  = fill_vaddr_i[VA_W-1:PAGE_BITS];
        rt.wr_bank = bank_of(fill_kind_i);
        rt.wr_ok   = fill_valid_i && !flush;   // flush outranks a fill
    end

    tlb_base_reg #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ptbase_we_i),
        .wdata_i (ptbase_wdata_i),
        .base_o  (ptbase_q_o),
        .flush_o (flush)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        tlb_tag_bank #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_tags (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush_i  (flush),
            .wr_en_i  (rt.wr_ok && rt.wr_bank == 2'(g)),
            .wr_idx_i (rt.wr_idx),
            .wr_tag_i (rt.wr_tag),
            .rd_idx_i (rt.rd_idx),
            .rd_tag_i (rt.rd_tag),
            .hit_o    (bank_hit[g])
        );
    end

    tlb_frame_bank #(.ENTRIES(ENTRIES), .FRAME_W(FRAME_W)) u_frames (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (rt.wr_ok),
        .wr_idx_i   (rt.wr_idx),
        .wr_frame_i (fill_frame_i),
        .rd_idx_i   (rt.rd_idx),
        .rd_frame_o (rd_frame)
    );

    always_comb begin
        rsp_hit_o    = req_valid_i && bank_hit[rt.rd_bank];
        rsp_paddr_o  = {rd_frame, req_vaddr_i[PAGE_BITS-1:0]};
        miss_req_o   = req_valid_i && !bank_hit[rt.rd_bank];
        miss_vaddr_o = req_vaddr_i;
        miss_kind_o  = req_kind_i;
    end

    assert_hit_xor_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit_o && miss_req_o));

    assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |-> (!rsp_hit_o && !miss_req_o));

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> (rsp_paddr_o[PAGE_BITS-1:0] == req_vaddr_i[PAGE_BITS-1:0]));

    // After a flush cycle nothing can hit until a new fill lands.
    assert_no_hit_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ptbase_we_i |=> !rsp_hit_o);

endmodule

// File: tb/sim_xlat_tlb.sv
module sim_xlat_tlb;

    localparam int VA_W = 32;
    localparam int PA_W = 32;
    localparam int FW   = PA_W - 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid_i = 1'b0;
    logic [VA_W-1:0] req_vaddr_i = '0;
    logic [1:0]      req_kind_i = '0;
    logic            rsp_hit_o;
    logic [PA_W-1:0] rsp_paddr_o;
    logic            miss_req_o;
    logic [VA_W-1:0] miss_vaddr_o;
    logic [1:0]      miss_kind_o;
    logic            fill_valid_i = 1'b0;
    logic [VA_W-1:0] fill_vaddr_i = '0;
    logic [1:0]      fill_kind_i = '0;
    logic [FW-1:0]   fill_frame_i = '0;
    logic            ptbase_we_i = 1'b0;
    logic [PA_W-1:0] ptbase_wdata_i = '0;
    logic [PA_W-1:0] ptbase_q_o;

    always #4 clk = ~clk;

    xlat_tlb #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(12), .ENTRIES(16)) u0 (.*);

    typedef struct {
        bit              valid;
        bit              hit;
        logic [PA_W-1:0] pa;
        logic [VA_W-1:0] va;
        logic [1:0]      kind;
        bit              chk_base;
        logic [PA_W-1:0] base;
        string           rq;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic next_cycle();
        @(negedge clk);
        req_valid_i  = 1'b0;
        fill_valid_i = 1'b0;
        ptbase_we_i  = 1'b0;
    endtask

    task automatic look(input bit v, input logic [VA_W-1:0] va, input logic [1:0] k,
                        input bit ehit, input logic [PA_W-1:0] epa, input string rq);
        exp_t e;
        req_valid_i = v;
        req_vaddr_i = va;
        req_kind_i  = k;
        e.valid = v; e.hit = ehit; e.pa = epa; e.va = va; e.kind = k;
        e.chk_base = 0; e.base = '0; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic expect_base(input logic [PA_W-1:0] b, input string rq);
        exp_t e;
        e.valid = 0; e.hit = 0; e.pa = '0; e.va = '0; e.kind = '0;
        e.chk_base = 1; e.base = b; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic fill(input logic [VA_W-1:0] va, input logic [1:0] k, input logic [FW-1:0] f);
        fill_valid_i = 1'b1;
        fill_vaddr_i = va;
        fill_kind_i  = k;
        fill_frame_i = f;
    endtask

    task automatic base_wr(input logic [PA_W-1:0] d);
        ptbase_we_i    = 1'b1;
        ptbase_wdata_i = d;
    endtask

    // Monitor: compares each queued expectation shortly after its drive edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (e.chk_base) begin
                    if (ptbase_q_o !== e.base) begin
                        errors++;
                        $display("FAIL %s base actual %h expected %h", e.rq, ptbase_q_o, e.base);
                    end
                end else begin
                    bit emiss;
                    emiss = e.valid && !e.hit;
                    if (rsp_hit_o !== e.hit || miss_req_o !== emiss) begin
                        errors++;
                        $display("FAIL %s va %h hit/miss actual %b/%b expected %b/%b",
                                 e.rq, e.va, rsp_hit_o, miss_req_o, e.hit, emiss);
                    end else if (e.hit && rsp_paddr_o !== e.pa) begin
                        errors++;
                        $display("FAIL %s va %h paddr actual %h expected %h",
                                 e.rq, e.va, rsp_paddr_o, e.pa);
                    end else if (emiss && (miss_vaddr_o !== e.va || miss_kind_o !== e.kind)) begin
                        errors++;
                        $display("FAIL %s miss fields actual %h/%b expected %h/%b",
                                 e.rq, miss_vaddr_o, miss_kind_o, e.va, e.kind);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, base zero
        next_cycle(); look(1, 32'h0000_1234, 2'b01, 0, '0, "R1");
        expect_base(32'h0, "R1");
        next_cycle(); look(1, 32'h0000_3456, 2'b00, 0, '0, "R1");

        // R2/R3: load fill then hit
        next_cycle(); fill(32'h0000_3000, 2'b01, 20'hABCDE);
        next_cycle(); look(1, 32'h0000_3456, 2'b01, 1, 32'hABCD_E456, "R3");
        // R5: other kinds unaffected
        next_cycle(); look(1, 32'h0000_3456, 2'b00, 0, '0, "R5");
        next_cycle(); look(1, 32'h0000_3456, 2'b10, 0, '0, "R5");
        // R4: code 11 uses load bank
        next_cycle(); look(1, 32'h0000_3FFF, 2'b11, 1, 32'hABCD_EFFF, "R4");
        // R2: aliases on same slot miss
        next_cycle(); look(1, 32'h0001_3456, 2'b01, 0, '0, "R2");
        next_cycle(); look(1, 32'h8000_3456, 2'b01, 0, '0, "R2");

        // R9: fill and lookup in the same cycle -> miss, next cycle hit
        next_cycle(); fill(32'h0001_3000, 2'b00, 20'h11111);
                      look(1, 32'h0001_3008, 2'b00, 0, '0, "R9");
        next_cycle(); look(1, 32'h0001_3008, 2'b00, 1, 32'h1111_1008, "R9");
        // R10: load tag at slot 3 still valid but frame replaced
        next_cycle(); look(1, 32'h0000_3456, 2'b01, 1, 32'h1111_1456, "R10");

        // R4: store bank, offset extremes
        next_cycle(); fill(32'h0000_F000, 2'b10, 20'h22222);
        next_cycle(); look(1, 32'h0000_FFFF, 2'b10, 1, 32'h2222_2FFF, "R4");
        next_cycle(); look(1, 32'h0000_F000, 2'b10, 1, 32'h2222_2000, "R3");
        next_cycle(); look(1, 32'h0000_FFFF, 2'b01, 0, '0, "R4");

        // R6: idle strobe gives neither hit nor miss
        next_cycle(); look(0, 32'h0000_F000, 2'b10, 0, '0, "R6");

        // R7/R8: base write with same-cycle fill
        next_cycle(); base_wr(32'h1234_5FFF); fill(32'h0000_5000, 2'b01, 20'h33333);
        next_cycle(); expect_base(32'h1234_5000, "R7");
                      look(1, 32'h0000_5000, 2'b01, 0, '0, "R8");
        next_cycle(); look(1, 32'h0000_3456, 2'b01, 0, '0, "R7");
        next_cycle(); look(1, 32'h0001_3008, 2'b00, 0, '0, "R7");
        next_cycle(); look(1, 32'h0000_F000, 2'b10, 0, '0, "R7");

        // R5: refill after flush works again
        next_cycle(); fill(32'h0000_5000, 2'b01, 20'h44444);
        next_cycle(); look(1, 32'h0000_5ABC, 2'b01, 1, 32'h4444_4ABC, "R5");

        next_cycle();
        next_cycle();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule